// File: doc/BRIEF.md
# Replayable FIFO Buffer with Occupancy Flags

This block is a first-in first-out store of 4096 nine-bit words. The producer and the consumer have no address lines. Each side gives an active-low strobe, and two internal pointers supply the write and read locations. The strobes may arrive with no relation to the system clock. Each strobe is sampled into the clock domain, and only its high-to-low transition starts an operation. The ninth data bit is stored and returned like any other bit, so it can carry parity for a check that happens outside the block.

Three flags report how much is stored: empty, full and a half-full mark. A write strobe while the buffer is full has no effect, and a read strobe while it is empty has no effect. The buffer therefore cannot overflow or underflow.

A replay input moves the read pointer back to location zero and keeps the write pointer where it is. After a replay, every word written since the last reset can be read again, for example after a receiver reports a corrupted block. A reset input clears both pointers.

Top module: `fifo_replay`

## Requirements
- R1: Words leave in the order they were written, and all 9 bits, including bit 8, come back unchanged.
- R2: A high-to-low transition of `wr_n` while `full_flag` is 0 stores `din` at the write pointer. The operation takes effect at the second rising clock edge after `wr_n` is first sampled low.
- R3: A write transition while `full_flag` is 1 is refused. The stored words and the occupancy stay unchanged.
- R4: A high-to-low transition of `rd_n` while `empty_flag` is 0 loads the next word onto `dout` at the second rising edge after `rd_n` is sampled low. `dout` then holds that word until the next accepted read.
- R5: A read transition while `empty_flag` is 1 is ignored. `dout` keeps its value and `empty_flag` stays 1.
- R6: `rs_n` sampled low at a clock edge clears both pointers and the occupancy, gives `empty_flag`=1, `full_flag`=0, `half_flag`=0, and sets `dout` to 0. `rs_n` takes priority over `rt_n`.
- R7: `rt_n` sampled low while `rs_n` is high moves the read pointer to location 0 and keeps the write pointer. The reads that follow return the words written since reset, starting with the first one.
- R8: After a replay, the occupancy equals the number of words written since reset, and the flags reflect that number.
- R9: `half_flag` is 1 when the occupancy is greater than 2048 and 0 when it is 2048 or less.
- R10: `empty_flag` is 1 exactly when the occupancy is 0, and `full_flag` is 1 exactly when it is 4096.
- R11: A read transition and a write transition accepted at the same edge leave the occupancy unchanged.
- R12: A strobe held low performs only one operation. Strobe transitions that reach their operating edge while `rt_n` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rs_n | input | 1 | Synchronous active-low reset of pointers and flags |
| rt_n | input | 1 | Active-low replay: rewinds the read pointer to 0 |
| wr_n | input | 1 | Active-low write strobe; its falling edge writes one word |
| rd_n | input | 1 | Active-low read strobe; its falling edge reads one word |
| din | input | 9 | Word to be written |
| dout | output | 9 | Last word read, held between reads |
| empty_flag | output | 1 | High when the buffer holds no words |
| full_flag | output | 1 | High when the buffer holds 4096 words |
| half_flag | output | 1 | High when more than 2048 words are held |

## Verification
The assertions check the cycle-level rules on every clock:
- a full or empty buffer stays that way when the operation is refused;
- the occupancy never exceeds the depth;
- a simultaneous read and write keeps the count;
- a replay zeroes the read pointer and leaves the write pointer alone;
- `dout` stays stable between reads;
- a strobe gives at most one edge pulse.

Data order, the returned bit patterns, the exact threshold crossings at 2048/2049, and replay after partial reads and after complete reads can only be shown by the bench's scenarios. Each scenario compares the design against a queue model.

// File: rtl/fifo_replay_pkg.sv
// Package: default geometry shared by the replayable FIFO and its bench.
// Assumes the depth is at least 2.
package fifo_replay_pkg;
    localparam int unsigned WORD_BITS   = 9;
    localparam int unsigned WORD_COUNT  = 4096;
endpackage

// File: rtl/strobe_edge.sv
// Module: samples an active-low, clock-unrelated strobe and emits a one-cycle
// pulse on each high-to-low transition. Assumes strobe pulses last at least
// two clock cycles low and two high. Reset treats the strobe as already low,
// so a strobe held low through reset never fires.
module strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic fall
);
    logic samp_q;
    logic prev_q;

    // Sample stage and previous-value stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            samp_q <= strobe_n;
            prev_q <= samp_q;
        end
    end

    // Falling edge: the strobe was high last sample and is low now.
    always_comb fall = prev_q & ~samp_q;

    AST_SINGLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R12
endmodule

// File: rtl/fifo_ptr_ctrl.sv
// Module: owns the read and write pointers, the occupancy count and the status
// flags. It decides which strobe edges are accepted. Replay rewinds the read
// pointer and reloads the count from the write position. Assumes that replay
// data is meaningful only while at most DEPTH words have been written since
// reset.
module fifo_ptr_ctrl #(
    parameter int unsigned DEPTH = fifo_replay_pkg::WORD_COUNT,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          retx_n,
    input  logic          wr_fall,
    input  logic          rd_fall,
    output logic          wr_go,
    output logic          rd_go,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          empty,
    output logic          full,
    output logic          half
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
    localparam logic [AW-1:0] LAST_LOC = AW'(DEPTH - 1);

    logic [CW-1:0] count_q;
    logic [AW-1:0] wr_ptr_q;
    logic [AW-1:0] rd_ptr_q;
    logic          wrapped_q;

    // Status flags decoded from the registered occupancy.
    always_comb begin
        empty = (count_q == '0);
        full  = (count_q == FULL_CNT);
        half  = (count_q > HALF_CNT);
    end

    // Accept an edge only outside replay and only when the flag allows it.
    always_comb begin
        wr_go   = wr_fall & ~full  & retx_n;
        rd_go   = rd_fall & ~empty & retx_n;
        wr_addr = wr_ptr_q;
        rd_addr = rd_ptr_q;
    end

    // Pointer, wrap marker and occupancy update with reset and replay priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            wr_ptr_q  <= '0;
            rd_ptr_q  <= '0;
            wrapped_q <= 1'b0;
        end else if (!retx_n) begin
            rd_ptr_q <= '0;
            count_q  <= wrapped_q ? FULL_CNT : {1'b0, wr_ptr_q};
        end else begin
            if (wr_go) begin
                wr_ptr_q <= (wr_ptr_q == LAST_LOC) ? '0 : wr_ptr_q + 1'b1;
                if (wr_ptr_q == LAST_LOC) wrapped_q <= 1'b1;
            end
            if (rd_go) begin
                rd_ptr_q <= (rd_ptr_q == LAST_LOC) ? '0 : rd_ptr_q + 1'b1;
            end
            unique case ({wr_go, rd_go})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL_CNT); // R10
    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_go && retx_n) |=> full); // R3
    AST_EMPTY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_go && retx_n) |=> empty); // R5
    AST_FLAG_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full) && !(half && empty)); // R9
    AST_SIMUL_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && rd_go) |=> $stable(count_q)); // R11
    AST_REPLAY_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
        !retx_n |=> (rd_ptr_q == '0)); // R7
    AST_REPLAY_KEEPS_WPTR: assert property (@(posedge clk) disable iff (!rst_n)
        !retx_n |=> $stable(wr_ptr_q)); // R7
endmodule

// File: rtl/fifo_store.sv
// Module: the word array with one write port and a registered read port.
// Read data is held until the next read enable. Assumes that the controller
// never enables a read and a write of the same location in one cycle.
module fifo_store #(
    parameter int unsigned WIDTH = fifo_replay_pkg::WORD_BITS,
    parameter int unsigned DEPTH = fifo_replay_pkg::WORD_COUNT,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Array write; contents are not cleared by reset.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Output register loaded only by an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr];
    end

    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R4
endmodule

// File: rtl/fifo_replay.sv
// Module: top of the replayable FIFO. It detects the edges of both strobes,
// runs the pointer controller and holds the word array. rs_n is the
// synchronous reset. rt_n rewinds the read side for replay.
module fifo_replay #(
    parameter int unsigned WIDTH = fifo_replay_pkg::WORD_BITS,
    parameter int unsigned DEPTH = fifo_replay_pkg::WORD_COUNT,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rs_n,
    input  logic             rt_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             empty_flag,
    output logic             full_flag,
    output logic             half_flag
);
    logic [1:0]    strobe_vec;
    logic [1:0]    fall_vec;
    logic          wr_go;
    logic          rd_go;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;

    // Index 0 is the write strobe and index 1 is the read strobe.
    always_comb strobe_vec = {rd_n, wr_n};

    for (genvar g = 0; g < 2; g++) begin : g_edge
        strobe_edge u_edge (
            .clk      (clk),
            .rst_n    (rs_n),
            .strobe_n (strobe_vec[g]),
            .fall     (fall_vec[g])
        );
    end

    fifo_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rs_n),
        .retx_n  (rt_n),
        .wr_fall (fall_vec[0]),
        .rd_fall (fall_vec[1]),
        .wr_go   (wr_go),
        .rd_go   (rd_go),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .empty   (empty_flag),
        .full    (full_flag),
        .half    (half_flag)
    );

    fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rs_n),
        .wr_en   (wr_go),
        .wr_addr (wr_addr),
        .wr_data (din),
        .rd_en   (rd_go),
        .rd_addr (rd_addr),
        .rd_data (dout)
    );
endmodule

// File: tb/test_fifo_replay.sv
// Bench: directed scenarios against a queue model; each task checks itself.
module test_fifo_replay;
    localparam int DEPTH = 4096;
    localparam int HALF  = DEPTH / 2;

    logic       clk = 1'b0;
    logic       rs_n = 1'b0;
    logic       rt_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic [8:0] din  = '0;
    logic [8:0] dout;
    logic       empty_flag, full_flag, half_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [8:0] q[$];
    logic [8:0] hist[$];
    logic [8:0] exp_out = '0;

    always #5 clk = ~clk;

    fifo_replay i_fifo_replay (
        .clk(clk), .rs_n(rs_n), .rt_n(rt_n), .wr_n(wr_n), .rd_n(rd_n),
        .din(din), .dout(dout), .empty_flag(empty_flag),
        .full_flag(full_flag), .half_flag(half_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic flags(input string req);
        chk({req, " empty"}, 32'(empty_flag), 32'(q.size() == 0));
        chk({req, " full"},  32'(full_flag),  32'(q.size() == DEPTH));
        chk({req, " half"},  32'(half_flag),  32'(q.size() > HALF));
    endtask

    // Strobe pulse: two cycles low, two cycles high, applied at negedges.
    task automatic pulse(input bit do_w, input bit do_r, input logic [8:0] d);
        @(negedge clk);
        din = d;
        if (do_w) wr_n = 1'b0;
        if (do_r) rd_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        rd_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr_word(input logic [8:0] d);
        pulse(1'b1, 1'b0, d);
        if (q.size() < DEPTH) begin
            q.push_back(d);
            hist.push_back(d);
        end
    endtask

    task automatic rd_word(input string req);
        pulse(1'b0, 1'b1, '0);
        if (q.size() > 0) exp_out = q.pop_front();
        chk(req, 32'(dout), 32'(exp_out));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rs_n = 1'b0;
        repeat (2) @(negedge clk);
        rs_n = 1'b1;
        repeat (3) @(negedge clk);
        q.delete();
        hist.delete();
        exp_out = '0;
        chk("R6 dout", 32'(dout), 0);
        flags("R6");
    endtask

    task automatic replay();
        @(negedge clk);
        rt_n = 1'b0;
        repeat (2) @(negedge clk);
        rt_n = 1'b1;
        @(negedge clk);
        q = hist;
    endtask

    task automatic t_order();
        do_reset();
        wr_word(9'h1A5); wr_word(9'h05A); wr_word(9'h100); wr_word(9'h0FF); wr_word(9'h155);
        flags("R2");
        for (int i = 0; i < 5; i++) rd_word("R1 R4 order");
        flags("R10 after drain");
    endtask

    task automatic t_empty_read();
        do_reset();
        pulse(1'b0, 1'b1, '0);
        chk("R5 dout after empty read", 32'(dout), 0);
        flags("R5");
        wr_word(9'h133);
        rd_word("R4 single");
        pulse(1'b0, 1'b1, '0);
        chk("R5 dout held", 32'(dout), 32'h133);
        flags("R5 still empty");
    endtask

    task automatic t_fill();
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            wr_word(9'((i * 37 + 5) % 512));
            if (q.size() == HALF)     chk("R9 half at 2048", 32'(half_flag), 0);
            if (q.size() == HALF + 1) chk("R9 half at 2049", 32'(half_flag), 1);
        end
        flags("R10 full");
        wr_word(9'h1EE);
        flags("R3 refused");
        for (int i = 0; i < DEPTH; i++) begin
            rd_word("R3 R1 drain");
            if (q.size() == HALF) chk("R9 half drop", 32'(half_flag), 0);
        end
        flags("R10 empty");
    endtask

    task automatic t_replay_partial();
        do_reset();
        for (int i = 0; i < 10; i++) wr_word(9'(i * 51 + 1));
        for (int i = 0; i < 4; i++) rd_word("R4 pre-replay");
        replay();
        flags("R8 partial");
        for (int i = 0; i < 10; i++) rd_word("R7 replay partial");
        flags("R8 drained");
    endtask

    task automatic t_replay_complete();
        do_reset();
        for (int i = 0; i < 6; i++) wr_word(9'(300 - i * 7));
        for (int i = 0; i < 6; i++) rd_word("R4 first pass");
        flags("R10 empty before replay");
        replay();
        flags("R8 complete");
        wr_word(9'h0C3);
        hist.delete();
        for (int i = 0; i < 7; i++) rd_word("R7 write pointer kept");
        flags("R7 end");
    endtask

    task automatic t_simul();
        do_reset();
        wr_word(9'h011); wr_word(9'h122); wr_word(9'h033);
        pulse(1'b1, 1'b1, 9'h144);
        exp_out = q.pop_front();
        q.push_back(9'h144);
        chk("R11 simul dout", 32'(dout), 32'(exp_out));
        flags("R11 count kept");
        for (int i = 0; i < 3; i++) rd_word("R11 remaining");
        flags("R11 empty");
    endtask

    task automatic t_hold_and_replay_ignore();
        do_reset();
        @(negedge clk);
        din = 9'h0AB;
        wr_n = 1'b0;
        repeat (10) @(negedge clk);
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
        q.push_back(9'h0AB);
        hist.push_back(9'h0AB);
        flags("R12 one write");
        rd_word("R12 held data");
        flags("R12 only one");
        @(negedge clk);
        rt_n = 1'b0;
        pulse(1'b1, 1'b0, 9'h1FF);
        rt_n = 1'b1;
        @(negedge clk);
        q = hist;
        flags("R12 write during replay");
        rd_word("R12 replayed word");
        pulse(1'b0, 1'b1, '0);
        chk("R12 no extra word", 32'(dout), 32'h0AB);
        flags("R12 empty end");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_order();
        t_empty_read();
        t_simul();
        t_replay_partial();
        t_replay_complete();
        t_hold_and_replay_ignore();
        t_fill();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule